// File: doc/BRIEF.md
# Nonzero-Select Compress, Gather and Scatter Unit

This block turns a per-element test into vector form so that an operation runs only on the elements that pass it. On a start pulse it takes a source vector and a scalar addend. It marks every nonzero element in a mask register. It then scans the mask one bit per clock and builds a packed list of the marked positions, in rising order, along with a count of them. The list drives three phases. The gather phase copies only the marked operands into a dense buffer. The compute phase adds the scalar to each live entry of that buffer. The scatter phase writes each sum back to its original position in a destination store.

Destination positions that are not marked keep their previous contents. The destination store can be preloaded through a simple write port while the unit is idle. Its whole contents are visible on an output bus. When no element is marked, the unit skips gather, compute and scatter and reports completion straight after the scan.

Top module: `vcg_compress_unit`

## Requirements
- R1: After reset, busy and done are 0, the mask and the count are 0, and every destination entry reads 0.
- R2: After a run, mask bit i is 1 exactly when source element i (bits i*W+W-1 down to i*W of the source bus) is nonzero.
- R3: After a run, the count equals the number of set mask bits.
- R4: Index list entries 0 to count-1 (entry j at bits j*IW+IW-1 down to j*IW, with IW = log2 N) hold the marked positions in strictly rising order.
- R5: Each marked destination position ends holding its source element plus the addend, modulo 2^W.
- R6: Each unmarked destination position keeps the value it held before the run.
- R7: With k > 0 marked elements, done rises N+2+2k clocks after the clock edge that samples start.
- R8: With no marked element, the count is 0, done rises N+1 clocks after the start edge, and the destination is unchanged.
- R9: A destination write is applied on the next edge while idle and is ignored while busy.
- R10: Busy is 1 from the clock after start until done. Done is high for exactly one clock, after which busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; sampled while idle |
| src_flat | input | N*W | Source vector, element i at bits i*W+W-1:i*W |
| addend | input | W | Scalar added to each marked element |
| dst_we | input | 1 | Destination preload write enable |
| dst_waddr | input | IW | Destination preload address |
| dst_wdata | input | W | Destination preload data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock completion pulse |
| mask_o | output | N | Nonzero mask |
| count_o | output | log2(N+1) | Number of marked elements |
| idx_flat_o | output | N*IW | Packed index list |
| dst_flat_o | output | N*W | Destination store contents |

## Verification
A fault in the scan pointer or the count register shows up as a wrong count or index list as soon as done rises. It also moves the done edge away from N+2+2k, because the gather and scatter phases run for count clocks. A wrong index entry or a wrong dense-buffer slot sends a sum to the wrong place. That is visible on the destination bus the moment done is seen, either as a wrong sum at a marked position or as a changed value at an unmarked one. The directed runs therefore check mask, count, list, destination and latency together at that cycle.

// File: rtl/vcg_pkg.sv
package vcg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MASK,
        ST_SCAN,
        ST_GATHER,
        ST_COMPUTE,
        ST_SCATTER,
        ST_DONE
    } vcg_state_e;

    // Width of a counter able to hold values 0..n
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/vcg_index_builder.sv
module vcg_index_builder #(
    parameter int N  = 8,
    parameter int W  = 8,
    localparam int IW = $clog2(N),
    localparam int CW = vcg_pkg::cnt_width(N)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic                   step,
    input  logic [N-1:0][W-1:0]    elems,
    output logic [N-1:0]           mask_o,
    output logic [N-1:0][IW-1:0]   idx_o,
    output logic [CW-1:0]          count_o,
    output logic                   last_o
);
    logic [N-1:0]         mask_q;
    logic [N-1:0][IW-1:0] idx_q;
    logic [CW-1:0]        count_q;
    logic [IW-1:0]        ptr_q;
    logic [N-1:0]         nz;

    // Per-element nonzero test
    for (genvar g = 0; g < N; g++) begin : g_nz
        assign nz[g] = |elems[g];
    end

    assign last_o = (ptr_q == IW'(N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            idx_q   <= '0;
            count_q <= '0;
            ptr_q   <= '0;
        end else if (load) begin
            mask_q  <= nz;
            count_q <= '0;
            ptr_q   <= '0;
        end else if (step) begin
            if (mask_q[ptr_q]) begin
                idx_q[count_q[IW-1:0]] <= ptr_q;
                count_q                <= count_q + 1'b1;
            end
            if (!last_o) ptr_q <= ptr_q + 1'b1;
        end
    end

    assign mask_o  = mask_q;
    assign idx_o   = idx_q;
    assign count_o = count_q;

    // R3: the count can never pass the vector length
    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(N));

    // R4: each new entry lies above the entry written before it
    p_idx_rising_r4: assert property (@(posedge clk) disable iff (rst)
        (step && mask_q[ptr_q] && count_q != '0)
            |-> idx_q[count_q[IW-1:0] - 1'b1] < ptr_q);

endmodule

// File: rtl/vcg_dense_buf.sv
module vcg_dense_buf #(
    parameter int N  = 8,
    parameter int W  = 8,
    localparam int IW = $clog2(N),
    localparam int CW = vcg_pkg::cnt_width(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_addr,
    input  logic [W-1:0]   wr_data,
    input  logic           add_en,
    input  logic [W-1:0]   add_val,
    input  logic [CW-1:0]  live_cnt,
    input  logic [IW-1:0]  rd_addr,
    output logic [W-1:0]   rd_data
);
    logic [N-1:0][W-1:0] dense_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dense_q <= '0;
        end else if (wr_en) begin
            dense_q[wr_addr] <= wr_data;
        end else if (add_en) begin
            for (int i = 0; i < N; i++) begin
                if (CW'(i) < live_cnt) dense_q[i] <= dense_q[i] + add_val;
            end
        end
    end

    assign rd_data = dense_q[rd_addr];

    // R5: the add phase only runs on a non-empty compressed vector
    p_add_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        add_en |-> live_cnt != '0);

endmodule

// File: rtl/vcg_compress_unit.sv
module vcg_compress_unit #(
    parameter int N  = 8,
    parameter int W  = 8,
    localparam int IW = $clog2(N),
    localparam int CW = vcg_pkg::cnt_width(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [N*W-1:0]  src_flat,
    input  logic [W-1:0]    addend,
    input  logic            dst_we,
    input  logic [IW-1:0]   dst_waddr,
    input  logic [W-1:0]    dst_wdata,
    output logic            busy,
    output logic            done,
    output logic [N-1:0]    mask_o,
    output logic [CW-1:0]   count_o,
    output logic [N*IW-1:0] idx_flat_o,
    output logic [N*W-1:0]  dst_flat_o
);
    import vcg_pkg::*;

    vcg_state_e           state_q;
    logic [N-1:0][W-1:0]  opm_q;
    logic [N-1:0][W-1:0]  dst_q;
    logic [W-1:0]         addend_q;
    logic [CW-1:0]        k_q;

    logic [N-1:0]         mask;
    logic [N-1:0][IW-1:0] idx;
    logic [CW-1:0]        count;
    logic                 scan_last;
    logic [W-1:0]         dense_rd;
    logic                 k_last;

    vcg_index_builder #(.N(N), .W(W)) u_idx (
        .clk     (clk),
        .rst     (rst),
        .load    (state_q == ST_MASK),
        .step    (state_q == ST_SCAN),
        .elems   (opm_q),
        .mask_o  (mask),
        .idx_o   (idx),
        .count_o (count),
        .last_o  (scan_last)
    );

    vcg_dense_buf #(.N(N), .W(W)) u_dense (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (state_q == ST_GATHER),
        .wr_addr  (k_q[IW-1:0]),
        .wr_data  (opm_q[idx[k_q[IW-1:0]]]),
        .add_en   (state_q == ST_COMPUTE),
        .add_val  (addend_q),
        .live_cnt (count),
        .rd_addr  (k_q[IW-1:0]),
        .rd_data  (dense_rd)
    );

    assign k_last = (k_q == count - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            opm_q    <= '0;
            dst_q    <= '0;
            addend_q <= '0;
            k_q      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        opm_q    <= src_flat;
                        addend_q <= addend;
                        state_q  <= ST_MASK;
                    end else if (dst_we) begin
                        dst_q[dst_waddr] <= dst_wdata;
                    end
                end
                ST_MASK: state_q <= ST_SCAN;
                ST_SCAN: begin
                    k_q <= '0;
                    if (scan_last) state_q <= (mask == '0) ? ST_DONE : ST_GATHER;
                end
                ST_GATHER: begin
                    k_q <= k_q + 1'b1;
                    if (k_last) begin
                        k_q     <= '0;
                        state_q <= ST_COMPUTE;
                    end
                end
                ST_COMPUTE: state_q <= ST_SCATTER;
                ST_SCATTER: begin
                    dst_q[idx[k_q[IW-1:0]]] <= dense_rd;
                    k_q <= k_q + 1'b1;
                    if (k_last) state_q <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign done       = (state_q == ST_DONE);
    assign mask_o     = mask;
    assign count_o    = count;
    assign idx_flat_o = idx;
    assign dst_flat_o = dst_q;

    // R3: at completion the count matches the mask population
    p_count_matches_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> count == CW'($countones(mask)));

    // R6: scatter only ever targets a marked position
    p_scatter_marked_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCATTER) |-> mask[idx[k_q[IW-1:0]]]);

    // R8: gather never starts on an empty mask
    p_gather_nonempty_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GATHER) |-> count != '0);

    // R9: outside idle and scatter, the destination store holds still
    p_dst_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_SCATTER && state_q != ST_IDLE) |=> $stable(dst_q));

    // R10: done lasts a single clock
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/vcg_compress_unit_bench.sv
module vcg_compress_unit_bench;
    localparam int N  = 8;
    localparam int W  = 8;
    localparam int IW = $clog2(N);
    localparam int CW = $clog2(N + 1);
    localparam time CLK_PERIOD = 10ns;

    logic            clk = 0;
    logic            rst;
    logic            start;
    logic [N*W-1:0]  src_flat;
    logic [W-1:0]    addend;
    logic            dst_we;
    logic [IW-1:0]   dst_waddr;
    logic [W-1:0]    dst_wdata;
    logic            busy, done;
    logic [N-1:0]    mask_o;
    logic [CW-1:0]   count_o;
    logic [N*IW-1:0] idx_flat_o;
    logic [N*W-1:0]  dst_flat_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [N-1:0][W-1:0] dst_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    vcg_compress_unit #(.N(N), .W(W)) u_vcg_compress_unit (
        .clk(clk), .rst(rst), .start(start), .src_flat(src_flat), .addend(addend),
        .dst_we(dst_we), .dst_waddr(dst_waddr), .dst_wdata(dst_wdata),
        .busy(busy), .done(done), .mask_o(mask_o), .count_o(count_o),
        .idx_flat_o(idx_flat_o), .dst_flat_o(dst_flat_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_dst(input string tag);
        for (int i = 0; i < N; i++)
            check(tag, 64'(dst_flat_o[i*W +: W]), 64'(dst_m[i]));
    endtask

    task automatic test_reset();
        rst = 1; start = 0; src_flat = '0; addend = '0;
        dst_we = 0; dst_waddr = '0; dst_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        dst_m = '0;
        check("R1 busy", 64'(busy), 0);
        check("R1 done", 64'(done), 0);
        check("R1 mask", 64'(mask_o), 0);
        check("R1 count", 64'(count_o), 0);
        check_dst("R1 dst");
    endtask

    task automatic write_dst(input int a, input logic [W-1:0] d);
        @(negedge clk);
        dst_we = 1; dst_waddr = IW'(a); dst_wdata = d;
        @(negedge clk);
        dst_we = 0;
        dst_m[a] = d;
        check("R9 idle write", 64'(dst_flat_o[a*W +: W]), 64'(d));
    endtask

    // inj: attempt a destination write to position ia while busy
    task automatic run_vec(input logic [N-1:0][W-1:0] v, input logic [W-1:0] a,
                           input bit inj, input int ia, input logic [W-1:0] id);
        logic [N-1:0] em;
        int k;
        int n;
        int exp_lat;
        logic [N-1:0][IW-1:0] eidx;
        em = '0; k = 0; eidx = '0;
        for (int i = 0; i < N; i++) begin
            if (v[i] != '0) begin
                em[i] = 1'b1;
                eidx[k] = IW'(i);
                k++;
                dst_m[i] = v[i] + a;
            end
        end
        exp_lat = (k == 0) ? N + 1 : N + 2 + 2 * k;

        @(negedge clk);
        src_flat = v; addend = a; start = 1;
        @(posedge clk);
        @(negedge clk);
        start = 0;
        check("R10 busy after start", 64'(busy), 1);
        n = 0;
        while (!done && n < 200) begin
            if (inj && n == 2) begin
                dst_we = 1; dst_waddr = IW'(ia); dst_wdata = id;
            end
            @(posedge clk);
            @(negedge clk);
            dst_we = 0;
            n++;
            if (!done) check("R10 busy during run", 64'(busy), 1);
        end
        if (k == 0) check("R8 empty latency", 64'(n), 64'(exp_lat));
        else        check("R7 latency", 64'(n), 64'(exp_lat));
        check("R2 mask", 64'(mask_o), 64'(em));
        check(k == 0 ? "R8 count zero" : "R3 count", 64'(count_o), 64'(k));
        for (int j = 0; j < k; j++)
            check("R4 index", 64'(idx_flat_o[j*IW +: IW]), 64'(eidx[j]));
        check_dst(k == 0 ? "R8 dst unchanged" : (inj ? "R9 busy write ignored / R6 R5" : "R5 R6 dst"));
        @(negedge clk);
        check("R10 done pulse", 64'(done), 0);
        check("R10 idle", 64'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [N-1:0][W-1:0] v;
        test_reset();
        for (int i = 0; i < N; i++) write_dst(i, W'(8'hA0 + i));

        // mixed pattern, busy-time write to an unmarked position (R6, R9)
        v = '0; v[1] = 8'h05; v[4] = 8'hFF; v[5] = 8'h03; v[7] = 8'h07;
        run_vec(v, 8'h02, 1'b1, 0, 8'h55);

        // every element marked, wraparound at FF (R5)
        for (int i = 0; i < N; i++) v[i] = W'(i * 3 + 1);
        v[6] = 8'hFF;
        run_vec(v, 8'h01, 1'b0, 0, '0);

        // empty mask (R8)
        v = '0;
        run_vec(v, 8'h10, 1'b0, 0, '0);

        // single marked element at the top position
        v = '0; v[N-1] = 8'h40;
        run_vec(v, 8'h04, 1'b0, 0, '0);

        // single marked element at position 0
        write_dst(3, 8'h33);
        v = '0; v[0] = 8'h01;
        run_vec(v, 8'h80, 1'b0, 0, '0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule